// File: doc/BRIEF.md
# Vector Byte Table Lookup Engine

This engine gathers eight bytes out of a small table held in a local register file of 32 entries, each 128 bits wide. A request supplies a 64-bit word that holds eight byte-wide indices, the number of the first table register, a table length of one to four registers, a fill-mode bit and a 64-bit starting value. Each index picks one byte from the run of consecutive registers that forms the table. The run wraps from the last register back to register 0. The picked byte lands in the result lane that matches the index lane.

An index that falls past the end of the table does not touch its lane. In zero-fill mode that lane reads as zero. In keep mode it keeps the matching byte of the supplied starting value. The engine handles one lane per clock. It raises busy while it works and pulses done once the eighth lane has been resolved. Table contents are loaded through a separate write port. That port is only open while the engine is idle.

Top module: `vec_byte_lookup`

## Requirements
- R1: After reset, busy and done are low, result is all zeros and wrReady is high.
- R2: A request is taken only when reqValid is high while busy is low. Busy then stays high for exactly 8 cycles, and done is high for one cycle, the cycle right after busy falls. A reqValid seen while busy is high is ignored.
- R3: Index lane k sits in bits 8k+7..8k of reqIndices, and its looked-up byte is placed in bits 8k+7..8k of result.
- R4: reqLen encodes a table of reqLen+1 registers. An index is in range exactly when it is below 16*(reqLen+1).
- R5: For an in-range index i, the half-register number h is (2*reqStart + i[7:3]) mod 64. The byte taken is byte i[2:0] (bits 8*i[2:0]+7 down to 8*i[2:0]) of register h/2. An even h takes bits 63..0 of that register and an odd h takes bits 127..64.
- R6: A table that runs past register 31 continues at register 0.
- R7: With reqKeep low (zero-fill), an out-of-range lane gives 0x00 in result.
- R8: With reqKeep high (keep mode), an out-of-range lane gives the matching byte of reqInit.
- R9: wrReady is low while busy is high. A write presented with wrEn while busy is high does not change the register file.
- R10: When the engine is idle, result holds its value until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register file write strobe |
| wrAddr | input | 5 | Register number to write |
| wrData | input | 128 | Register write data |
| wrReady | output | 1 | High when a write is accepted |
| reqValid | input | 1 | Lookup request strobe |
| reqIndices | input | 64 | Eight byte indices, lane k at bits 8k+7..8k |
| reqStart | input | 5 | First table register |
| reqLen | input | 2 | Table length minus one, in registers |
| reqKeep | input | 1 | 0: zero-fill, 1: keep reqInit bytes |
| reqInit | input | 64 | Starting value used in keep mode |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle pulse when the result is complete |
| result | output | 64 | Looked-up bytes |

## Verification
The assertions assume that request inputs are sampled only in the cycle a request is taken. They also assume that writers wait on wrReady and do not expect a write presented during busy to land. The bench breaks the second assumption on purpose and checks that such writes are dropped. The hold property assumes reqValid stays low during idle cycles between requests. The stimulus drives reqValid for one cycle per lookup, except in the overlap test, where it is held across busy cycles to show it is ignored. The table is filled completely before the first lookup, so every read returns a known value.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
  localparam int VBL_LANE_SEL_W = 3;

  typedef struct packed {
    logic load;
    logic step;
    logic [VBL_LANE_SEL_W-1:0] lane;
  } vbl_strobe_t;
endpackage

// File: rtl/vbl_regfile.sv
module vbl_regfile #(
  parameter int REG_COUNT = 32,
  parameter int REG_W = 128,
  localparam int REG_AW = $clog2(REG_COUNT)
) (
  input  logic clk,
  input  logic wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [REG_W-1:0] rdData
);
  logic [REG_W-1:0] store [REG_COUNT];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  assign rdData = store[rdAddr];
endmodule

// File: rtl/vbl_ctrl.sv
module vbl_ctrl
  import vbl_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  output logic busy,
  output logic done,
  output vbl_strobe_t strobe
);
  localparam logic [VBL_LANE_SEL_W-1:0] LAST_LANE = VBL_LANE_SEL_W'(LANES - 1);

  logic [VBL_LANE_SEL_W-1:0] laneCnt;
  logic accept;

  assign accept = reqValid && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      laneCnt <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        laneCnt <= '0;
      end else if (busy) begin
        laneCnt <= laneCnt + 1'b1;
        if (laneCnt == LAST_LANE) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.load = accept;
    strobe.step = busy;
    strobe.lane = laneCnt;
  end
endmodule

// File: rtl/vbl_datapath.sv
module vbl_datapath
  import vbl_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LANE_W = 8,
  parameter int REG_COUNT = 32,
  parameter int REG_W = 128,
  parameter int LEN_W = 2,
  localparam int IDX_W = LANES * LANE_W,
  localparam int REG_AW = $clog2(REG_COUNT)
) (
  input  logic clk,
  input  logic rstN,
  input  vbl_strobe_t strobe,
  input  logic [IDX_W-1:0] reqIndices,
  input  logic [REG_AW-1:0] reqStart,
  input  logic [LEN_W-1:0] reqLen,
  input  logic reqKeep,
  input  logic [IDX_W-1:0] reqInit,
  input  logic [REG_W-1:0] rdData,
  output logic [REG_AW-1:0] rdAddr,
  output logic [IDX_W-1:0] result
);
  localparam int HALF_W = REG_AW + 1;
  localparam int HALF_BITS = REG_W / 2;
  localparam int BYTES_PER_HALF = HALF_BITS / LANE_W;
  localparam int BSEL_W = $clog2(BYTES_PER_HALF);
  localparam int BYTES_PER_REG = REG_W / LANE_W;
  localparam int LIMIT_W = LANE_W + 2;

  logic [IDX_W-1:0] idxReg;
  logic [REG_AW-1:0] startReg;
  logic [LEN_W-1:0] lenReg;

  logic [LANE_W-1:0] curIdx;
  logic [LIMIT_W-1:0] tblRegs;
  logic [LIMIT_W-1:0] limit;
  logic inRange;
  logic [HALF_W-1:0] halfNum;
  logic [HALF_BITS-1:0] halfWord;
  logic [BSEL_W-1:0] byteSel;
  logic [LANE_W-1:0] pickByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg   <= '0;
      startReg <= '0;
      lenReg   <= '0;
    end else if (strobe.load) begin
      idxReg   <= reqIndices;
      startReg <= reqStart;
      lenReg   <= reqLen;
    end
  end

  always_comb begin
    curIdx   = idxReg[strobe.lane*LANE_W +: LANE_W];
    tblRegs  = LIMIT_W'(lenReg) + LIMIT_W'(1);
    limit    = tblRegs * LIMIT_W'(BYTES_PER_REG);
    inRange  = LIMIT_W'(curIdx) < limit;
    halfNum  = {startReg, 1'b0} + HALF_W'(curIdx >> BSEL_W);
    rdAddr   = halfNum[HALF_W-1:1];
    halfWord = halfNum[0] ? rdData[REG_W-1:HALF_BITS] : rdData[HALF_BITS-1:0];
    byteSel  = curIdx[BSEL_W-1:0];
    pickByte = halfWord[byteSel*LANE_W +: LANE_W];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] laneByte;
    logic laneHit;

    assign laneHit = strobe.step && inRange && (strobe.lane == VBL_LANE_SEL_W'(k));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneByte <= '0;
      end else if (strobe.load) begin
        laneByte <= reqKeep ? reqInit[k*LANE_W +: LANE_W] : '0;
      end else if (laneHit) begin
        laneByte <= pickByte;
      end
    end

    assign result[k*LANE_W +: LANE_W] = laneByte;
  end
endmodule

// File: rtl/vec_byte_lookup.sv
module vec_byte_lookup
  import vbl_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LANE_W = 8,
  parameter int REG_COUNT = 32,
  parameter int REG_W = 128,
  parameter int LEN_W = 2,
  localparam int IDX_W = LANES * LANE_W,
  localparam int REG_AW = $clog2(REG_COUNT)
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [REG_W-1:0] wrData,
  output logic wrReady,
  input  logic reqValid,
  input  logic [IDX_W-1:0] reqIndices,
  input  logic [REG_AW-1:0] reqStart,
  input  logic [LEN_W-1:0] reqLen,
  input  logic reqKeep,
  input  logic [IDX_W-1:0] reqInit,
  output logic busy,
  output logic done,
  output logic [IDX_W-1:0] result
);
  vbl_strobe_t strobe;
  logic [REG_AW-1:0] rdAddr;
  logic [REG_W-1:0] rdData;

  assign wrReady = !busy;

  vbl_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .busy(busy), .done(done), .strobe(strobe)
  );

  vbl_regfile #(.REG_COUNT(REG_COUNT), .REG_W(REG_W)) u_rf (
    .clk(clk), .wrEn(wrEn && wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  vbl_datapath #(
    .LANES(LANES), .LANE_W(LANE_W), .REG_COUNT(REG_COUNT),
    .REG_W(REG_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqIndices(reqIndices), .reqStart(reqStart), .reqLen(reqLen),
    .reqKeep(reqKeep), .reqInit(reqInit), .rdData(rdData),
    .rdAddr(rdAddr), .result(result)
  );
endmodule

// File: rtl/vbl_checker.sv
module vbl_checker #(
  parameter int LANES = 8,
  parameter int LANE_W = 8,
  parameter int REG_COUNT = 32,
  parameter int REG_W = 128,
  parameter int LEN_W = 2,
  localparam int IDX_W = LANES * LANE_W,
  localparam int REG_AW = $clog2(REG_COUNT)
) (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic [REG_AW-1:0] wrAddr,
  input logic [REG_W-1:0] wrData,
  input logic wrReady,
  input logic reqValid,
  input logic [IDX_W-1:0] reqIndices,
  input logic [REG_AW-1:0] reqStart,
  input logic [LEN_W-1:0] reqLen,
  input logic reqKeep,
  input logic [IDX_W-1:0] reqInit,
  input logic busy,
  input logic done,
  input logic [IDX_W-1:0] result
);
  logic [7:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyRun == 8'(LANES)));

  p_ready_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !wrReady);

  p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && !reqKeep) |=> (result == '0));

  p_keep_init_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && reqKeep) |=> (result == $past(reqInit)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqValid) |=> $stable(result));
endmodule

bind vec_byte_lookup vbl_checker #(
  .LANES(LANES), .LANE_W(LANE_W), .REG_COUNT(REG_COUNT),
  .REG_W(REG_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/vec_byte_lookup_bench.sv
`timescale 1ns/1ps
module vec_byte_lookup_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [127:0] wrData = '0;
  logic wrReady;
  logic reqValid = 1'b0;
  logic [63:0] reqIndices = '0;
  logic [4:0] reqStart = '0;
  logic [1:0] reqLen = '0;
  logic reqKeep = 1'b0;
  logic [63:0] reqInit = '0;
  logic busy;
  logic done;
  logic [63:0] result;

  always #2.5 clk = ~clk;

  vec_byte_lookup u_vec_byte_lookup (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrReady(wrReady), .reqValid(reqValid), .reqIndices(reqIndices),
    .reqStart(reqStart), .reqLen(reqLen), .reqKeep(reqKeep), .reqInit(reqInit),
    .busy(busy), .done(done), .result(result)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string curReq = "R1";

  // Reference model state
  logic [127:0] mMem [32];
  logic mBusy = 0, mDone = 0, wasBusy;
  logic [63:0] mRes = '0, mPend = '0;
  int mCnt = 0;

  function automatic logic [63:0] refLookup(logic [63:0] ind, int start, int len,
                                            logic keep, logic [63:0] init);
    logic [63:0] r = keep ? init : 64'h0;
    for (int k = 0; k < 8; k++) begin
      int idx = int'(ind[8*k +: 8]);
      if (idx < 16 * (len + 1)) begin
        int h = (2 * start + idx / 8) % 64;
        int bitPos = (h % 2) * 64 + (idx % 8) * 8;
        r[8*k +: 8] = mMem[h / 2][bitPos +: 8];
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mRes = '0; mCnt = 0;
    end else begin
      wasBusy = mBusy;
      if (wrEn && !wasBusy) mMem[wrAddr] = wrData;
      mDone = 0;
      if (wasBusy) begin
        mCnt++;
        if (mCnt == 8) begin
          mBusy = 0; mDone = 1; mRes = mPend;
        end
      end else if (reqValid) begin
        mBusy = 1; mCnt = 0;
        mPend = refLookup(reqIndices, int'(reqStart), int'(reqLen), reqKeep, reqInit);
        mRes = reqKeep ? reqInit : 64'h0;
      end
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2", "busy", 64'(busy), 64'(mBusy));
      chk("R2", "done", 64'(done), 64'(mDone));
      chk("R9", "wrReady", 64'(wrReady), 64'(!mBusy));
      if (!mBusy) chk(curReq, "result", result, mRes);
    end
  end

  function automatic logic [7:0] pat(int r, int b);
    return 8'((r * 37 + b * 11 + 3) & 255);
  endfunction

  task automatic loadAll();
    for (int r = 0; r < 32; r++) begin
      logic [127:0] w;
      for (int b = 0; b < 16; b++) w[8*b +: 8] = pat(r, b);
      @(negedge clk);
      wrEn = 1; wrAddr = 5'(r); wrData = w;
    end
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic lookup(logic [63:0] ind, int start, int len, logic keep, logic [63:0] init);
    @(negedge clk);
    reqValid = 1; reqIndices = ind; reqStart = 5'(start);
    reqLen = 2'(len); reqKeep = keep; reqInit = init;
    @(negedge clk);
    reqValid = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", 64'(busy), 64'h0);
    chk("R1", "done", 64'(done), 64'h0);
    chk("R1", "result", result, 64'h0);
    chk("R1", "wrReady", 64'(wrReady), 64'h1);
    rstN = 1;
    loadAll();

    curReq = "R3";
    lookup(64'h0706050403020100, 0, 0, 0, 64'h0);
    lookup(64'h000102030F0E0D0C, 7, 0, 0, 64'h0);

    curReq = "R5";
    lookup(64'h1F18171008070100, 3, 1, 0, 64'h0);
    lookup(64'h3F2A19080C1B2E3D, 10, 3, 0, 64'h0);

    curReq = "R4";
    lookup(64'h10100F0F10000F10, 4, 0, 0, 64'h0);
    lookup(64'hFF80413F403F3020, 12, 3, 0, 64'h0);
    lookup(64'h302F20211F1E1011, 6, 2, 0, 64'h0);

    curReq = "R6";
    lookup(64'h3F3830281810080F, 31, 3, 0, 64'h0);
    lookup(64'h1F1E171610090807, 31, 1, 0, 64'h0);
    lookup(64'h2F28201F18100800, 30, 2, 0, 64'h0);

    curReq = "R7";
    lookup(64'h90FF2011100F0100, 2, 0, 0, 64'h0);

    curReq = "R8";
    lookup(64'h90FF2011100F0100, 2, 0, 1, 64'hA5C3_5A3C_1122_3344);
    lookup(64'hFFFFFFFFFFFFFFFF, 9, 3, 1, 64'h0123_4567_89AB_CDEF);

    // R2: reqValid held through busy with changed fields is ignored
    curReq = "R2";
    @(negedge clk);
    reqValid = 1; reqIndices = 64'h0001020304050607; reqStart = 5'd20;
    reqLen = 2'd0; reqKeep = 0; reqInit = '0;
    @(negedge clk);
    reqIndices = 64'h3F3F3F3F3F3F3F3F; reqStart = 5'd1; reqLen = 2'd3;
    reqKeep = 1; reqInit = 64'hDEAD_BEEF_DEAD_BEEF;
    repeat (4) @(negedge clk);
    reqValid = 0;
    repeat (10) @(negedge clk);

    // R9: writes during busy are dropped
    curReq = "R9";
    @(negedge clk);
    reqValid = 1; reqIndices = 64'h0F0D0B0907050301; reqStart = 5'd5;
    reqLen = 2'd0; reqKeep = 0;
    @(negedge clk);
    reqValid = 0;
    wrEn = 1; wrAddr = 5'd5; wrData = {128{1'b1}};
    repeat (3) @(negedge clk);
    wrEn = 0;
    repeat (8) @(negedge clk);
    lookup(64'h0E0C0A0806040200, 5, 0, 0, 64'h0);

    // R10: idle hold, result compared on every idle clock
    curReq = "R10";
    repeat (6) @(negedge clk);

    curReq = "R5";
    for (int i = 0; i < 40; i++) begin
      logic [63:0] ind;
      for (int k = 0; k < 8; k++) ind[8*k +: 8] = 8'($urandom_range(0, 80));
      lookup(ind, int'($urandom_range(0, 31)), int'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), {$urandom, $urandom});
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule